// File: doc/BRIEF.md
# Dual-Clock Tagged Word Buffer

This block sits between a processing core and its mesh communication interface. The core pushes data words into it on the core clock. The interface pulls words out on its own communication clock, and the two clocks need not be related. The block stores up to DEPTH words between the two sides, so the core and the interface can run at different moments and rates.

The read side is never stalled, which suits a statically scheduled interface that performs a transfer on every cycle whether or not data is ready. Each word that comes out carries a one-bit tag. A strobed read from a non-empty buffer returns the oldest stored word with the tag set. A strobed read from an empty buffer returns a zero word with the tag clear, and a consumer discards any word whose tag is clear. The write side exposes a full flag. A write presented while the buffer is full is dropped and reported with a one-cycle overflow pulse.

Each side keeps its pointer in binary for addressing and publishes it as a Gray code. Each Gray pointer crosses into the other clock domain through a two-flop synchronizer. Empty is decided on the read clock and full on the write clock.

Top module: `vtag_cdc_fifo`

## Requirements
- R1: While either reset is held, and after both are released with no traffic, rd_empty is 1, wr_full is 0, rd_tag is 0 and wr_overflow is 0.
- R2: A read strobe (rd_en high at a rising rclk edge) while rd_empty is 1 makes rd_tag 0 and rd_data all zeros after that edge, and consumes nothing: a word written afterwards is the next word returned.
- R3: A read strobe while rd_empty is 0 makes rd_tag 1 after that rclk edge, with rd_data equal to the oldest stored word. A tag of 1 means valid and 0 means invalid.
- R4: Words come out in the order they were written, across any number of wraps of the storage.
- R5: wr_full is 1 exactly when DEPTH words are stored (after the read pointer has crossed). A write while wr_full is 1 stores nothing, and wr_overflow is 1 for the single wclk cycle after that edge.
- R6: rd_tag is 0 in every rclk cycle that follows an edge where rd_en was low.
- R7: Each published pointer changes by at most one bit per clock of its own domain.
- R8: After a write into an empty buffer, rd_empty falls within 3 rising rclk edges. After a read from a full buffer, wr_full falls within 3 rising wclk edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Core-side clock |
| wrst_n | input | 1 | Active-low reset, core side |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Buffer holds DEPTH words |
| wr_overflow | output | 1 | One-cycle pulse after a dropped write |
| rclk | input | 1 | Interface-side clock |
| rrst_n | input | 1 | Active-low reset, interface side |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Returned word, zero when invalid |
| rd_tag | output | 1 | 1 = returned word valid, 0 = invalid |
| rd_empty | output | 1 | No stored word visible to the read side |

## Verification
Some internal faults show up on the next read as a wrong tag or a wrong word. These include a read pointer that advances on an empty read, a write pointer that advances while full, and a Gray encoding that miscompares. Each such fault is seen at the first strobe after the fault, or at the empty read that ends a drain. A synchronizer or flag fault shows up as rd_empty or wr_full failing to change within three edges of the other clock. Sweeping every fill level from one word to DEPTH words wraps both pointers many times, so a fault in the wrap bit appears within two passes.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  // pointer carries one extra wrap bit above the address
  function automatic int unsigned ptr_bits(input int unsigned depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/vtag_sync.sv
module vtag_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/vtag_store.sv
module vtag_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                     wclk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vtag_wr_side.sv
module vtag_wr_side #(
  parameter int DEPTH = 8,
  localparam int PW = vtag_pkg::ptr_bits(DEPTH),
  localparam int AW = PW - 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic          wr_full,
  output logic          wr_overflow,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // full: write pointer one lap ahead of the read pointer
  function automatic logic lap_ahead(input logic [PW-1:0] wg, input logic [PW-1:0] rg);
    return wg == {~rg[PW-1:PW-2], rg[PW-3:0]};
  endfunction

  logic [PW-1:0] wbin, wbin_nxt;

  assign wr_full  = lap_ahead(wgray, rgray_s);
  assign wr_fire  = wr_en && !wr_full;
  assign wbin_nxt = wbin + PW'(wr_fire);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin        <= '0;
      wgray       <= '0;
      wr_overflow <= 1'b0;
    end else begin
      wbin        <= wbin_nxt;
      wgray       <= to_gray(wbin_nxt);
      wr_overflow <= wr_en && wr_full;
    end
  end

  assert_drop_when_full_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && wr_full) |=> $stable(wgray));
  assert_overflow_pulse_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && wr_full) |=> wr_overflow);
  assert_no_false_overflow_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    !(wr_en && wr_full) |=> !wr_overflow);
  assert_wgray_step_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/vtag_rd_side.sv
module vtag_rd_side #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PW = vtag_pkg::ptr_bits(DEPTH),
  localparam int AW = PW - 1
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic [PW-1:0]     wgray_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     rgray,
  output logic              rd_empty,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] rbin, rbin_nxt;
  logic          rd_take;

  assign rd_empty = (rgray == wgray_s);
  assign rd_take  = rd_en && !rd_empty;
  assign rbin_nxt = rbin + PW'(rd_take);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_tag  <= 1'b0;
      rd_data <= '0;
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= to_gray(rbin_nxt);
      rd_tag  <= rd_take;
      rd_data <= rd_take ? mem_rdata : '0;
    end
  end

  assert_empty_read_invalid_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && rd_empty) |=> (!rd_tag && rd_data == '0));
  assert_empty_read_holds_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && rd_empty) |=> $stable(rgray));
  assert_nonempty_read_valid_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && !rd_empty) |=> rd_tag);
  assert_idle_tag_low_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_en |=> !rd_tag);
  assert_rgray_step_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/vtag_cdc_fifo.sv
module vtag_cdc_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_overflow,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              rd_empty
);
  localparam int PW = vtag_pkg::ptr_bits(DEPTH);
  localparam int AW = PW - 1;

  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     waddr, raddr;
  logic              wr_fire;
  logic [DATA_W-1:0] mem_rdata;

  vtag_wr_side #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .wr_full(wr_full), .wr_overflow(wr_overflow), .wr_fire(wr_fire),
    .waddr(waddr), .wgray(wgray)
  );

  vtag_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  vtag_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  vtag_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  vtag_rd_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray), .rd_empty(rd_empty),
    .rd_data(rd_data), .rd_tag(rd_tag)
  );
endmodule

// File: tb/test_vtag_cdc_fifo.sv
module test_vtag_cdc_fifo;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_full, wr_overflow, rd_tag, rd_empty;
  logic [DW-1:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 rclk = ~rclk;
  always #3.5 wclk = ~wclk;

  vtag_cdc_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_vtag_cdc_fifo (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_overflow(wr_overflow), .rclk(rclk), .rrst_n(rrst_n),
    .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .rd_empty(rd_empty)
  );

  function automatic logic [DW-1:0] pat(input int k, input int i);
    return (32'(k) * 32'h9E3779B1) + (32'(i) * 32'h01000193) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [DW-1:0] d, output logic ovf);
    @(posedge wclk); #1 wr_en = 1; wr_data = d;
    @(posedge wclk); #1 wr_en = 0; ovf = wr_overflow;
  endtask

  task automatic rd_word(output logic t, output logic [DW-1:0] d);
    @(posedge rclk); #1 rd_en = 1;
    @(posedge rclk); #1 rd_en = 0; t = rd_tag; d = rd_data;
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic t, ovf;
    logic [DW-1:0] d;
    repeat (3) @(posedge wclk);
    #1;
    // R1 during reset
    chk(rd_empty == 1 && wr_full == 0 && rd_tag == 0 && wr_overflow == 0, "R1 in reset",
        {rd_empty, wr_full, rd_tag, wr_overflow}, 4'b1000);
    wrst_n = 1; rrst_n = 1;
    repeat (4) @(posedge rclk);
    #1;
    chk(rd_empty == 1 && wr_full == 0 && rd_tag == 0 && wr_overflow == 0, "R1 after reset",
        {rd_empty, wr_full, rd_tag, wr_overflow}, 4'b1000);

    // R2 empty read is invalid and zero
    rd_word(t, d);
    chk(t == 0, "R2 empty tag", t, 0);
    chk(d == '0, "R2 empty data", d, 0);

    // R2 non-consuming: the next written word is returned
    wr_word(32'hCAFE0001, ovf);
    settle();
    // R6 idle: tag stays low with data present and no strobe
    chk(rd_tag == 0, "R6 idle tag", rd_tag, 0);
    rd_word(t, d);
    chk(t == 1 && d == 32'hCAFE0001, "R2 word after empty read", d, 32'hCAFE0001);
    @(posedge rclk); #1;
    chk(rd_tag == 0, "R6 tag after strobe drops", rd_tag, 0);

    // sweep every fill level, wrapping the pointers
    for (int k = 0; k < 2; k++) begin
      for (int n = 1; n <= DEPTH; n++) begin
        wr_word(pat(k * 16 + n, 0), ovf);
        repeat (3) @(posedge rclk);
        #1;
        chk(rd_empty == 0, "R8 empty falls", rd_empty, 0);
        for (int i = 1; i < n; i++) wr_word(pat(k * 16 + n, i), ovf);
        settle();
        chk(wr_full == (n == DEPTH), "R5 full flag", wr_full, (n == DEPTH));
        if (n == DEPTH) begin
          wr_word(32'hDEADBEEF, ovf);
          chk(ovf == 1, "R5 overflow pulse", ovf, 1);
          @(posedge wclk); #1;
          chk(wr_overflow == 0, "R5 overflow one cycle", wr_overflow, 0);
        end
        for (int i = 0; i < n; i++) begin
          rd_word(t, d);
          chk(t == 1, "R3 valid tag", t, 1);
          chk(d == pat(k * 16 + n, i), "R4 order", d, pat(k * 16 + n, i));
          if (n == DEPTH && i == 0) begin
            repeat (3) @(posedge wclk);
            #1;
            chk(wr_full == 0, "R8 full falls", wr_full, 0);
          end
        end
        rd_word(t, d);
        chk(t == 0 && d == '0, "R2 drained read", d, 0);
        settle();
        chk(rd_empty == 1, "R1 empty after drain", rd_empty, 1);
      end
    end
    done = 1;
    finish_run();
  end
endmodule